// File: doc/BRIEF.md
# Digit-Serial BCD Load Sequencer

This block writes new values into a multi-decade BCD counter one decade at a time, paced by the display scanner. The scanner supplies a one-hot set of digit strobes and a flag that is high during the gap between digits. A thumbwheel-style source places the BCD value for the decade currently being strobed on a 4-bit data input. An active-low load request enables the loading.

If the request is low on the clock edge where a digit strobe rises, that decade is claimed. The request is then held internally, so the external request may be removed while the strobe is still high. The block keeps sampling the BCD input until that strobe falls. One clock later it issues a single-cycle write that carries the decade index and the last sampled value. A request held low across several digit slots loads each of those decades in turn. Each decade occupies one slot of the scan.

While a load is in progress, the block raises an inhibit for the counter's carry and zero flags. The inhibit is lifted only when the request rises during a blanking gap and a strobe rise follows that gap. If the request rises at any other time, the inhibit stays asserted.

Top module: `digit_load_seq`

## Requirements
- R1: A decade is written only when its strobe rose while load_ni was sampled low. A request that first goes low after that strobe rose does not load that decade.
- R2: Once a decade has been claimed, raising load_ni before its strobe falls does not cancel the write.
- R3: wr_en_o goes high for exactly one cycle, on the clock after the claimed strobe is first sampled low. wr_data_o carries bcd_i as sampled on the last clock edge at which any strobe was high.
- R4: wr_idx_o is the bit position of the claimed strobe: strobe_i bit k gives index k. A strobe may hand over directly to another strobe with no gap, and each claimed decade is still written in order.
- R5: flag_inhibit_o is high on the cycle after any clock edge at which load_ni is sampled low.
- R6: flag_inhibit_o falls only on the cycle after a strobe rise. It falls only if, since the last low sample of load_ni, load_ni rose while blank_i was high. A rise of load_ni while blank_i is low leaves the inhibit set.
- R7: After reset, wr_en_o and flag_inhibit_o are low, and no write is issued in any slot that was not claimed.
- R8: A request that arrives while no strobe is active waits, and loads the decade of the next strobe that rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | NUM_DIGITS | One-hot digit strobes from the scanner |
| blank_i | input | 1 | High during the interdigit blanking gap |
| load_ni | input | 1 | Load request, active low |
| bcd_i | input | BCD_W | BCD value for the strobed decade |
| wr_en_o | output | 1 | Single-cycle decade write strobe |
| wr_idx_o | output | IDX_W | Index of the decade being written |
| wr_data_o | output | BCD_W | BCD value to write |
| flag_inhibit_o | output | 1 | Inhibit for the carry and zero flags |

## Verification
The bench changes the BCD input partway through a strobe. A design that latched the data at the strobe rise would write the stale value. It drops the request in the middle of a claimed strobe, which catches a design that cancels the load, and it raises a request only after a strobe is already high, which catches a design that wrongly loads that digit. It raises the request once during a strobe and once during blanking to tell a correct inhibit release apart from an eager one. A direct handover from one strobe to the next with no gap exposes an index or data mix-up between the two writes.

// File: rtl/digload_pkg.sv
package digload_pkg;
  localparam int unsigned DEF_DIGITS = 6;
  localparam int unsigned DEF_BCD_W  = 4;

  function automatic int unsigned idx_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strobe_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= '0;
    else         strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;
  assign fall_o = strobe_q & ~strobe_i;
endmodule

// File: rtl/onehot_idx.sv
module onehot_idx #(
  parameter int unsigned N = 6,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] oh_i,
  output logic [W-1:0] idx_o
);
  function automatic logic [N-1:0] bit_mask(int unsigned b);
    logic [N-1:0] m;
    m = '0;
    for (int k = 0; k < N; k++) m[k] = ((k >> b) & 1) == 1;
    return m;
  endfunction

  for (genvar b = 0; b < W; b++) begin : g_bit
    localparam logic [N-1:0] MASK = bit_mask(b);
    assign idx_o[b] = |(oh_i & MASK);
  end
endmodule

// File: rtl/flag_inhibit_ctl.sv
module flag_inhibit_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_ni,
  input  logic blank_i,
  input  logic any_rise_i,
  output logic inhibit_o
);
  logic load_q;
  logic rel_arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q    <= 1'b1;
      rel_arm_q <= 1'b0;
      inhibit_o <= 1'b0;
    end else begin
      load_q <= load_ni;
      if (!load_ni) begin
        inhibit_o <= 1'b1;
        rel_arm_q <= 1'b0;
      end else begin
        // release arms only on a request drop inside the blanking gap
        if (!load_q && blank_i) rel_arm_q <= 1'b1;
        if (any_rise_i && rel_arm_q) begin
          inhibit_o <= 1'b0;
          rel_arm_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/digit_load_seq.sv
module digit_load_seq
  import digload_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = DEF_DIGITS,
  parameter int unsigned BCD_W      = DEF_BCD_W,
  localparam int unsigned IDX_W     = idx_width(NUM_DIGITS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_DIGITS-1:0] strobe_i,
  input  logic                  blank_i,
  input  logic                  load_ni,
  input  logic [BCD_W-1:0]      bcd_i,
  output logic                  wr_en_o,
  output logic [IDX_W-1:0]      wr_idx_o,
  output logic [BCD_W-1:0]      wr_data_o,
  output logic                  flag_inhibit_o
);
  logic [NUM_DIGITS-1:0] rise, fall;
  logic [IDX_W-1:0]      rise_idx;
  logic                  any_rise, cur_fall;
  logic                  active_q;
  logic [IDX_W-1:0]      idx_q;
  logic [BCD_W-1:0]      data_q;

  strobe_edge #(.N(NUM_DIGITS)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i),
    .rise_o(rise), .fall_o(fall)
  );

  onehot_idx #(.N(NUM_DIGITS), .W(IDX_W)) u_enc (
    .oh_i(rise), .idx_o(rise_idx)
  );

  flag_inhibit_ctl u_inh (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_ni(load_ni), .blank_i(blank_i),
    .any_rise_i(any_rise), .inhibit_o(flag_inhibit_o)
  );

  assign any_rise = |rise;
  assign cur_fall = active_q & fall[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      idx_q     <= '0;
      data_q    <= '0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (|strobe_i) data_q <= bcd_i;
      if (cur_fall) begin
        wr_en_o   <= 1'b1;
        wr_idx_o  <= idx_q;
        wr_data_o <= data_q;
        active_q  <= 1'b0;
      end
      // claim on strobe rise; overrides the clear on a direct handover
      if (any_rise && !load_ni) begin
        active_q <= 1'b1;
        idx_q    <= rise_idx;
      end
    end
  end
endmodule

// File: rtl/digit_load_seq_chk.sv
module digit_load_seq_chk #(
  parameter int unsigned NUM_DIGITS = 6,
  parameter int unsigned IDX_W      = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_DIGITS-1:0] strobe_i,
  input logic                  load_ni,
  input logic                  wr_en_o,
  input logic [IDX_W-1:0]      wr_idx_o,
  input logic                  flag_inhibit_o
);
  // R3
  single_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  // R4
  written_strobe_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ((($past(strobe_i) >> wr_idx_o) & NUM_DIGITS'(1)) == '0));

  // R4
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_i));

  // R5
  inhibit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> flag_inhibit_o);

  // R6
  inhibit_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_inhibit_o) |-> $past(load_ni));
endmodule

bind digit_load_seq digit_load_seq_chk #(.NUM_DIGITS(NUM_DIGITS), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .load_ni(load_ni),
  .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .flag_inhibit_o(flag_inhibit_o)
);

// File: tb/digit_load_seq_tb.sv
`timescale 1ns/100ps
module digit_load_seq_tb;
  localparam int unsigned N = 6;
  localparam int unsigned W = 3;

  typedef struct packed { logic [W-1:0] idx; logic [3:0] data; } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] strobe = '0;
  logic         blank = 1'b1;
  logic         load_n = 1'b1;
  logic [3:0]   bcd = '0;
  logic         wr_en, inhibit;
  logic [W-1:0] wr_idx;
  logic [3:0]   wr_data;

  int   total = 0;
  int   bad = 0;
  exp_t expq[$];

  always #2.5 clk = ~clk;

  digit_load_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .blank_i(blank),
    .load_ni(load_n), .bcd_i(bcd), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .flag_inhibit_o(inhibit)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_wr(input int idx, input int data);
    exp_t e;
    e.idx = W'(idx);
    e.data = 4'(data);
    expq.push_back(e);
  endtask

  // monitor: compares each write against the scoreboard
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (expq.size() == 0) begin
        check(1'b0, "R1/R7 unexpected write idx", int'(wr_idx), -1);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(wr_idx == e.idx, "R4 write index", int'(wr_idx), int'(e.idx));
        check(wr_data == e.data, "R3 write data", int'(wr_data), int'(e.data));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R7 reset state
    check(wr_en == 1'b0, "R7 wr_en after reset", int'(wr_en), 0);
    check(inhibit == 1'b0, "R7 inhibit after reset", int'(inhibit), 0);

    // R1 R2 R5: claim decade 5, drop request mid-strobe
    load_n = 1'b0; tick(1);
    check(inhibit == 1'b1, "R5 inhibit on request", int'(inhibit), 1);
    expect_wr(5, 7);
    blank = 1'b0; strobe = N'(1) << 5; bcd = 4'd7; tick(2);
    load_n = 1'b1; tick(3);
    strobe = '0; blank = 1'b1; tick(3);
    check(inhibit == 1'b1, "R6 inhibit kept after drop in strobe", int'(inhibit), 1);

    // R7: unclaimed slot
    blank = 1'b0; strobe = N'(1) << 4; bcd = 4'd3; tick(4);
    strobe = '0; blank = 1'b1; tick(3);
    check(inhibit == 1'b1, "R6 inhibit still set", int'(inhibit), 1);

    // R3: data changes mid-strobe; R6 release in blanking
    load_n = 1'b0; tick(1);
    expect_wr(3, 9);
    blank = 1'b0; strobe = N'(1) << 3; bcd = 4'd2; tick(2);
    bcd = 4'd9; tick(2);
    strobe = '0; blank = 1'b1; tick(1);
    load_n = 1'b1; tick(2);
    check(inhibit == 1'b1, "R6 inhibit held until strobe rise", int'(inhibit), 1);
    blank = 1'b0; strobe = N'(1) << 2; bcd = 4'd5; tick(1);
    check(inhibit == 1'b0, "R6 inhibit released", int'(inhibit), 0);
    tick(3);
    strobe = '0; blank = 1'b1; tick(2);

    // R8: request with no strobe waits
    load_n = 1'b0; tick(5);
    check(wr_en == 1'b0, "R8 no write while waiting", int'(wr_en), 0);
    expect_wr(0, 4);
    blank = 1'b0; strobe = N'(1); bcd = 4'd4; tick(3);
    strobe = '0; blank = 1'b1; tick(1);
    load_n = 1'b1; tick(2);

    // R1: late request does not load decade 1
    blank = 1'b0; strobe = N'(1) << 1; bcd = 4'd8; tick(1);
    check(inhibit == 1'b0, "R6 release after R8 load", int'(inhibit), 0);
    load_n = 1'b0; tick(2);
    check(inhibit == 1'b1, "R5 inhibit on late request", int'(inhibit), 1);
    strobe = '0; blank = 1'b1; tick(2);
    expect_wr(4, 6);
    blank = 1'b0; strobe = N'(1) << 4; bcd = 4'd6; tick(3);
    strobe = '0; blank = 1'b1; tick(1);
    load_n = 1'b1; tick(3);

    // R4: direct handover, no gap
    load_n = 1'b0;
    expect_wr(5, 1);
    blank = 1'b0; strobe = N'(1) << 5; bcd = 4'd1; tick(2);
    expect_wr(4, 2);
    strobe = N'(1) << 4; bcd = 4'd2; tick(2);
    strobe = '0; blank = 1'b1; tick(3);
    load_n = 1'b1; tick(5);

    check(expq.size() == 0, "R1 all expected writes seen", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule